// File: doc/BRIEF.md
# Serial Port Register Front End

This block is the register and interrupt side of a serial port. A processor reaches it over a simple 32-bit memory-mapped bus that has an address, separate read and write strobes, write data and read data. The block holds a status word, a receive data holder, a baud divisor, three control words and a guard-time word. Received bytes arrive on a byte-wide port with a valid/ready handshake. Transmit bytes leave on a byte-wide output with a one-cycle valid strobe. A single level-sensitive interrupt line tells the processor that a received byte is waiting.

Bit shifting, baud generation, parity, framing and guard timing belong to other blocks. The divisor, control 2, control 3 and guard-time words are only stored and read back for those blocks. The status word has an unusual write rule. A value of 0x3FF or less replaces the whole word. A larger value is treated as a mask that can only clear bits.

Read data is combinational and valid in the same cycle as the read strobe. Every side effect of an access, such as clearing a flag or moving the interrupt, takes effect at the clock edge that ends the access.

Top module: `sio_reg_front`

## Requirements
- R1: After a synchronous active-low reset, the status word reads 0x000000C0 (bit 7 transmit-empty and bit 6 transmit-complete both set). The data, divisor, control 1–3 and guard-time words read 0. The interrupt is low and rx_ready is high.
- R2: rx_ready is high exactly while the receive-full flag (status bit 5) is clear. While that flag is set, a byte offered on the receive port is not taken and the held data does not change.
- R3: A byte that is taken while control 1 has both bit 13 (port enable) and bit 2 (receiver enable) set is stored and sets status bit 5. If either enable is clear, the byte is consumed and discarded, and nothing changes.
- R4: When a byte is stored and control 1 bit 5 (receive interrupt enable) is set, the interrupt is high from the next cycle.
- R5: A read of the data word (offset 0x04) returns the stored byte zero-extended, with bits 31:10 always 0. The same access clears status bit 5 and drops the interrupt.
- R6: A status write (offset 0x00) of a value no greater than 0x3FF replaces the status word with that value, with bit 7 forced to 1.
- R7: A status write of a value greater than 0x3FF ANDs the value into the current status word.
- R8: After a status write that leaves bit 5 clear, the interrupt is low. A status write that leaves bit 5 set does not change the interrupt.
- R9: A data write of a value below 0xF000 produces a one-cycle tx_valid pulse in the next cycle, with tx_data equal to the low byte, and sets status bit 6. Values of 0xF000 and above produce no pulse and change nothing.
- R10: A control 1 write (offset 0x0C) stores the value. If the new value has bit 5 set while status bit 5 is set, the interrupt rises at once.
- R11: The divisor (0x08), control 2 (0x10), control 3 (0x14) and guard-time (0x18) words store all 32 written bits and read them back unchanged.
- R12: Inside the 0x400-byte window, reads at any other offset, including offsets that are not word aligned, return 0. Writes there change no register and produce no transmit pulse.
- R13: The interrupt rises only in the cycle after a byte is stored or after a control 1 write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 10 | Byte offset within the register window |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while bus_rd is high |
| rx_valid | input | 1 | Receive byte offered |
| rx_data | input | 8 | Receive byte |
| rx_ready | output | 1 | Block can take a receive byte |
| tx_valid | output | 1 | One-cycle transmit strobe |
| tx_data | output | 8 | Transmit byte |
| irq | output | 1 | Level interrupt, receive byte waiting |

## Verification
The hardest situation to reach from the ports is an interrupt that changes state without any new byte arriving. One case is a control 1 write that enables the interrupt while a byte is already held. The other is a status write that clears or sets the receive-full flag directly. Both need a byte to be held first and then a particular bus write to follow. Directed sequences set up each case: a byte is taken with the interrupt disabled, and then control 1 is enabled or the status word is overwritten. A seeded random phase then mixes received bytes, enable settings and small and large status values, so that these orderings also occur next to each other. Every response is compared against a reference model kept in the bench.

// File: rtl/sio_pkg.sv
// Package: shared register map and bit positions for the serial register
// front end. Assumes word-aligned 32-bit registers inside a 1 KiB window.
package sio_pkg;
    localparam int ADDR_W     = 10;
    localparam int DATA_W     = 32;
    localparam int BYTE_W     = 8;
    localparam int IDX_W      = ADDR_W - 2;

    // word indices inside the window
    localparam int IDX_STAT   = 0;
    localparam int IDX_DATA   = 1;
    localparam int IDX_DIV    = 2;
    localparam int IDX_CTL1   = 3;
    localparam int IDX_GUARD  = 6;
    localparam int N_PLAIN    = IDX_GUARD - IDX_DIV + 1;

    // status bits
    localparam int ST_FULL    = 5;
    localparam int ST_DONE    = 6;
    localparam int ST_EMPTY   = 7;
    // control 1 bits
    localparam int C1_RXEN    = 2;
    localparam int C1_RXIE    = 5;
    localparam int C1_PORTEN  = 13;

    localparam logic [DATA_W-1:0] STAT_RESET  = 32'h0000_00C0;
    localparam logic [DATA_W-1:0] STAT_SMALL  = 32'h0000_03FF;
    localparam logic [DATA_W-1:0] TX_LIMIT    = 32'h0000_F000;
    localparam logic [DATA_W-1:0] DATA_MASK   = 32'h0000_03FF;
endpackage

// File: rtl/sio_plain_regs.sv
// Module: bank of plain storage words (divisor, control 1-3, guard time).
// Assumes one write strobe per word; words have no side effects.
module sio_plain_regs
    import sio_pkg::*;
#(
    parameter int N = N_PLAIN,
    parameter int W = DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N-1:0]      wr_sel,
    input  logic [W-1:0]      wdata,
    output logic [N-1:0][W-1:0] words_q
);
    for (genvar k = 0; k < N; k++) begin : g_word
        // store one word on its select, clear on reset
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                words_q[k] <= '0;
            end else if (wr_sel[k]) begin
                words_q[k] <= wdata;
            end
        end

        p_word_holds_r11: assert property (@(posedge clk) disable iff (!rst_n)
            !wr_sel[k] |=> $stable(words_q[k]));
    end
endmodule

// File: rtl/sio_stat_irq.sv
// Module: status word, receive holder and interrupt level.
// Assumes at most one bus access per cycle. Bus effects apply first,
// then a receive byte taken in the same cycle is applied on top.
module sio_stat_irq
    import sio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stat_wr,
    input  logic              data_rd,
    input  logic              ctl1_wr,
    input  logic              tx_fire,
    input  logic [DATA_W-1:0] wdata,
    input  logic              port_en,
    input  logic              rx_en,
    input  logic              rx_ie,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_data,
    output logic              rx_ready,
    output logic [DATA_W-1:0] stat_q,
    output logic [BYTE_W-1:0] hold_q,
    output logic              irq
);
    logic [DATA_W-1:0] stat_bus, stat_n;
    logic [BYTE_W-1:0] hold_n;
    logic              irq_bus, irq_n, take, store;

    assign rx_ready = !stat_q[ST_FULL];
    assign take     = rx_valid && rx_ready;
    assign store    = take && port_en && rx_en;

    // bus-side effects on status and interrupt
    always_comb begin
        stat_bus = stat_q;
        irq_bus  = irq;
        if (stat_wr) begin
            if (wdata <= STAT_SMALL) begin
                stat_bus = wdata;
                stat_bus[ST_EMPTY] = 1'b1;
            end else begin
                stat_bus = stat_q & wdata;
            end
            if (!stat_bus[ST_FULL]) irq_bus = 1'b0;
        end
        if (tx_fire) stat_bus[ST_DONE] = 1'b1;
        if (data_rd) begin
            stat_bus[ST_FULL] = 1'b0;
            irq_bus = 1'b0;
        end
        if (ctl1_wr && wdata[C1_RXIE] && stat_bus[ST_FULL]) irq_bus = 1'b1;
    end

    // receive-side effects layered on top of bus effects
    always_comb begin
        stat_n = stat_bus;
        irq_n  = irq_bus;
        hold_n = hold_q;
        if (store) begin
            stat_n[ST_FULL] = 1'b1;
            hold_n = rx_data;
            if (rx_ie) irq_n = 1'b1;
        end
    end

    // state registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= STAT_RESET;
            hold_q <= '0;
            irq    <= 1'b0;
        end else begin
            stat_q <= stat_n;
            hold_q <= hold_n;
            irq    <= irq_n;
        end
    end

    p_full_blocks_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !rx_ready) |=> $stable(hold_q));
    p_store_sets_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
        store |=> (stat_q[ST_FULL] && hold_q == $past(rx_data)));
    p_drop_keeps_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !(port_en && rx_en)) |=> $stable(hold_q));
    p_read_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && !store) |=> (!stat_q[ST_FULL] && !irq));
    p_small_sets_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr && wdata <= STAT_SMALL) |=> stat_q[ST_EMPTY]);
    p_irq_source_r13: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(store || ctl1_wr));
endmodule

// File: rtl/sio_reg_front.sv
// Module: top of the serial register front end. Decodes the bus window,
// muxes read data and drives the transmit strobe.
// Assumes bus_rd and bus_wr are never high in the same cycle.
module sio_reg_front
    import sio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [9:0]        bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    output logic              rx_ready,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    output logic              irq
);
    logic [IDX_W-1:0]             idx;
    logic                         aligned;
    logic [N_PLAIN-1:0]           plain_wr;
    logic [N_PLAIN-1:0][DATA_W-1:0] plain_q;
    logic [DATA_W-1:0]            stat_q, ctl1_q;
    logic [BYTE_W-1:0]            hold_q;
    logic                         stat_wr, data_rd, data_wr, ctl1_wr, tx_fire;

    assign idx     = bus_addr[ADDR_W-1:2];
    assign aligned = (bus_addr[1:0] == 2'b00);
    assign stat_wr = bus_wr && aligned && idx == IDX_STAT;
    assign data_wr = bus_wr && aligned && idx == IDX_DATA;
    assign data_rd = bus_rd && aligned && idx == IDX_DATA;
    assign ctl1_wr = bus_wr && aligned && idx == IDX_CTL1;
    assign tx_fire = data_wr && (bus_wdata < TX_LIMIT);
    assign ctl1_q  = plain_q[IDX_CTL1-IDX_DIV];

    for (genvar k = 0; k < N_PLAIN; k++) begin : g_sel
        assign plain_wr[k] = bus_wr && aligned && idx == IDX_W'(k + IDX_DIV);
    end

    sio_plain_regs #(.N(N_PLAIN), .W(DATA_W)) u_plain (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_sel  (plain_wr),
        .wdata   (bus_wdata),
        .words_q (plain_q)
    );

    sio_stat_irq u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .stat_wr  (stat_wr),
        .data_rd  (data_rd),
        .ctl1_wr  (ctl1_wr),
        .tx_fire  (tx_fire),
        .wdata    (bus_wdata),
        .port_en  (ctl1_q[C1_PORTEN]),
        .rx_en    (ctl1_q[C1_RXEN]),
        .rx_ie    (ctl1_q[C1_RXIE]),
        .rx_valid (rx_valid),
        .rx_data  (rx_data),
        .rx_ready (rx_ready),
        .stat_q   (stat_q),
        .hold_q   (hold_q),
        .irq      (irq)
    );

    // read data mux, zero for unmapped or misaligned offsets
    always_comb begin
        bus_rdata = '0;
        if (bus_rd && aligned) begin
            if (idx == IDX_STAT) begin
                bus_rdata = stat_q;
            end else if (idx == IDX_DATA) begin
                bus_rdata = {{(DATA_W-BYTE_W){1'b0}}, hold_q} & DATA_MASK;
            end else if (idx >= IDX_W'(IDX_DIV) && idx <= IDX_W'(IDX_GUARD)) begin
                bus_rdata = plain_q[idx - IDX_W'(IDX_DIV)];
            end
        end
    end

    // transmit strobe, one cycle after an accepted data write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_valid <= 1'b0;
            tx_data  <= '0;
        end else begin
            tx_valid <= tx_fire;
            if (tx_fire) tx_data <= bus_wdata[BYTE_W-1:0];
        end
    end

    p_tx_from_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> $past(bus_wr && aligned && idx == IDX_DATA && bus_wdata < TX_LIMIT));
    p_big_write_silent_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && bus_wdata >= TX_LIMIT) |=> !tx_valid);
    p_unmapped_read_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !aligned) |-> bus_rdata == '0);
endmodule

// File: tb/sio_reg_front_tb_top.sv
// Bench: directed corner cases plus seeded random traffic, each response
// compared with a reference model kept in bench variables.
module sio_reg_front_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [9:0]  bus_addr = '0;
    logic        bus_rd = 1'b0, bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        rx_ready, tx_valid, irq;
    logic [7:0]  tx_data;

    int checks = 0, fails = 0;
    bit done = 1'b0;

    // reference model
    logic [31:0] m_stat, m_plain [2:6];
    logic [7:0]  m_hold;
    logic        m_irq;

    always #10 clk = ~clk;

    sio_reg_front dut_i (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_read(input logic [9:0] a);
        if (a[1:0] != 2'b00) return 32'h0;
        case (a[9:2])
            8'd0: return m_stat;
            8'd1: return {24'h0, m_hold};
            8'd2, 8'd3, 8'd4, 8'd5, 8'd6: return m_plain[a[9:2]];
            default: return 32'h0;
        endcase
    endfunction

    task automatic model_reset();
        m_stat = 32'hC0; m_hold = '0; m_irq = 1'b0;
        for (int k = 2; k <= 6; k++) m_plain[k] = '0;
    endtask

    task automatic check_state(input string req);
        check({req, " irq"}, {31'h0, irq}, {31'h0, m_irq});
        check({req, " ready"}, {31'h0, rx_ready}, {31'h0, !m_stat[5]});
    endtask

    task automatic do_read(input logic [9:0] a, input string req);
        logic [31:0] e;
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #2;
        e = exp_read(a);
        check(req, bus_rdata, e);
        if (a == 10'h004) begin m_stat[5] = 1'b0; m_irq = 1'b0; end
        @(negedge clk);
        bus_rd = 1'b0;
        check_state(req);
    endtask

    task automatic do_write(input logic [9:0] a, input logic [31:0] d, input string req);
        logic fire;
        @(negedge clk);
        bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
        fire = 1'b0;
        if (a[1:0] == 2'b00) begin
            case (a[9:2])
                8'd0: begin
                    m_stat = (d <= 32'h3FF) ? (d | 32'h80) : (m_stat & d);
                    if (!m_stat[5]) m_irq = 1'b0;
                end
                8'd1: if (d < 32'hF000) begin fire = 1'b1; m_stat[6] = 1'b1; end
                8'd3: begin
                    m_plain[3] = d;
                    if (d[5] && m_stat[5]) m_irq = 1'b1;
                end
                8'd2, 8'd4, 8'd5, 8'd6: m_plain[a[9:2]] = d;
                default: ;
            endcase
        end
        @(negedge clk);
        bus_wr = 1'b0;
        check({req, " tx_valid"}, {31'h0, tx_valid}, {31'h0, fire});
        if (fire) check({req, " tx_data"}, {24'h0, tx_data}, {24'h0, d[7:0]});
        check_state(req);
        @(negedge clk);
        check({req, " tx pulse width"}, {31'h0, tx_valid}, 32'h0);
    endtask

    task automatic do_rx(input logic [7:0] b, input string req);
        @(negedge clk);
        rx_valid = 1'b1; rx_data = b;
        #2;
        check({req, " ready offered"}, {31'h0, rx_ready}, {31'h0, !m_stat[5]});
        if (!m_stat[5] && m_plain[3][13] && m_plain[3][2]) begin
            m_hold = b; m_stat[5] = 1'b1;
            if (m_plain[3][5]) m_irq = 1'b1;
        end
        @(negedge clk);
        rx_valid = 1'b0;
        check_state(req);
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset values
        check_state("R1");
        for (int k = 0; k <= 6; k++) do_read(10'(k * 4), "R1 reset read");

        // R3 drop when disabled, R2 ready stays
        do_rx(8'h5A, "R3 disabled drop");
        do_read(10'h000, "R3 status after drop");
        // enable port and receiver, no interrupt
        do_write(10'h00C, 32'h2004, "R10 ctl1 enable");
        do_rx(8'hA7, "R3 store");
        do_read(10'h000, "R3 status full");
        do_rx(8'h11, "R2 refused while full");
        // R10 enabling interrupt with pending byte
        do_write(10'h00C, 32'h2024, "R10 irq raise");
        // R8 large write keeping full bit: irq unchanged
        do_write(10'h000, 32'hFFFF_FFBF, "R8 keep irq");
        do_read(10'h000, "R7 and mask");
        // R5 data read
        do_read(10'h004, "R5 data read");
        // R4 store with interrupt enabled
        do_rx(8'hF3, "R4 irq on store");
        // R6 small write clears full, drops irq
        do_write(10'h000, 32'h0000_0001, "R6 R8 small write");
        do_read(10'h000, "R6 empty forced");
        // small write setting full bit directly: no irq
        do_write(10'h000, 32'h0000_0020, "R8 set full by write");
        do_read(10'h004, "R5 read after write");
        // R9 transmit
        do_write(10'h004, 32'h0000_EFC3, "R9 tx below limit");
        do_write(10'h004, 32'h0000_F000, "R9 tx at limit ignored");
        do_read(10'h000, "R9 done bit");
        // R11 plain words
        do_write(10'h008, 32'hDEAD_BEEF, "R11 divisor");
        do_write(10'h018, 32'h1234_5678, "R11 guard");
        do_read(10'h008, "R11 divisor back");
        do_read(10'h018, "R11 guard back");
        // R12 unmapped
        do_write(10'h01C, 32'hFFFF_FFFF, "R12 unmapped write");
        do_write(10'h00D, 32'h0000_0000, "R12 misaligned write");
        do_read(10'h01C, "R12 unmapped read");
        do_read(10'h3FC, "R12 top read");
        do_read(10'h00E, "R12 misaligned read");
        do_read(10'h00C, "R12 ctl1 intact");

        // random phase, R13 via irq comparisons
        for (int i = 0; i < 600; i++) begin
            int sel;
            logic [31:0] v;
            sel = $urandom_range(0, 7);
            v = $urandom;
            case (sel)
                0, 1: do_rx(8'(v), "R13 rand rx");
                2: do_read(10'h004, "R5 rand data read");
                3: do_read(10'(4 * $urandom_range(0, 8)), "R11 rand read");
                4: do_write(10'h000, v[0] ? (v & 32'h3FF) : (v | 32'h400), "R7 rand status");
                5: do_write(10'h00C, {18'h0, v[13], 7'h0, v[5], 2'h0, v[2], 2'h0}, "R10 rand ctl1");
                6: do_write(10'h004, v & 32'h1FFFF, "R9 rand tx");
                default: do_write(10'(4 * $urandom_range(2, 7)), v, "R11 rand plain");
            endcase
        end

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule